// File: doc/BRIEF.md
# Single-Issue Function Unit Dispatcher

This controller sits between an instruction decoder and a row of five execution units. It takes one decoded instruction at a time. Each instruction arrives with a bitmask that marks the units able to execute it. The controller enables exactly one of those units for one cycle. It then waits for that unit to report busy and later report idle again. The unit's busy period includes its register-file writeback. Only after that does the controller take the next instruction, so exactly one instruction is ever in flight.

Bit positions in the mask and in the enable and busy vectors are fixed:
- bit 0: arithmetic unit
- bit 1: logical unit
- bit 2: shift/rotate unit
- bit 3: condition-register unit
- bit 4: branch unit

When several bits are set, the lowest index wins. An all-zero mask means no unit can take the instruction. The controller consumes it and raises an illegal-instruction pulse instead of enabling a unit.

Top module: `fu_dispatch`

## Requirements
- R1: After reset, `insn_ready` is high, `fu_issue` is all zero and `illegal` is low.
- R2: `insn_ready` is high only while the controller is idle. An instruction is accepted on a rising edge where `insn_valid` and `insn_ready` are both high.
- R3: For an accepted non-zero mask, `fu_issue` equals the lowest set bit of the mask in the cycle right after acceptance. Bit i enables unit i, where 0 is arithmetic, 1 is logical, 2 is shift/rotate, 3 is condition-register and 4 is branch.
- R4: At most one bit of `fu_issue` is ever high, and an enable lasts exactly one cycle.
- R5: For an accepted all-zero mask, `illegal` is high for the single cycle after acceptance. No enable is raised and `insn_ready` stays high.
- R6: After issuing, the controller keeps `insn_ready` low until the selected unit's busy line has been seen high. The busy lines of other units have no effect, and a selected busy line that is still low does not count as completion.
- R7: Once the selected unit's busy line has been seen high, `insn_ready` returns high in the cycle after a rising edge where that line is low.
- R8: `insn_valid` is ignored while `insn_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Decoded instruction present |
| insn_fu_mask | input | NUM_FU | Units capable of executing the instruction |
| fu_busy | input | NUM_FU | Per-unit busy, high until writeback completes |
| insn_ready | output | 1 | Controller can accept an instruction |
| fu_issue | output | NUM_FU | One-hot unit enable, one cycle |
| illegal | output | 1 | One-cycle pulse for an instruction no unit can take |

## Verification
The hardest state to reach is the window between issue and the selected unit's first busy cycle. There a premature completion would look like correct behaviour unless the selected busy line is deliberately held low. The stimulus sweeps all 32 masks. For each issued instruction it holds the selected unit idle for two cycles while raising a different unit's busy line and presenting a stray illegal instruction. The selected unit's busy line is raised only after that. The busy length varies with the mask, so both one-cycle and multi-cycle writebacks are covered.

// File: rtl/fu_dispatch.sv
module fu_dispatch #(
  parameter int NUM_FU = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic [NUM_FU-1:0] insn_fu_mask,
  input  logic [NUM_FU-1:0] fu_busy,
  output logic              insn_ready,
  output logic [NUM_FU-1:0] fu_issue,
  output logic              illegal
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT_UP, S_WAIT_DOWN} state_t;

  state_t            state_q;
  logic [NUM_FU-1:0] sel_q;
  logic              illegal_q;

  wire              accept   = insn_valid && (state_q == S_IDLE);
  wire [NUM_FU-1:0] pick     = insn_fu_mask & (~insn_fu_mask + 1'b1);
  wire              sel_busy = |(fu_busy & sel_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      sel_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= accept && (insn_fu_mask == '0);
      unique case (state_q)
        S_IDLE:
          if (accept && insn_fu_mask != '0) begin
            sel_q   <= pick;
            state_q <= S_ISSUE;
          end
        S_ISSUE:     state_q <= S_WAIT_UP;
        S_WAIT_UP:   if (sel_busy)  state_q <= S_WAIT_DOWN;
        S_WAIT_DOWN: if (!sel_busy) state_q <= S_IDLE;
        default:     state_q <= S_IDLE;
      endcase
    end
  end

  assign insn_ready = (state_q == S_IDLE);
  assign fu_issue   = (state_q == S_ISSUE) ? sel_q : '0;
  assign illegal    = illegal_q;

endmodule

// File: rtl/fu_dispatch_chk.sv
module fu_dispatch_chk #(
  parameter int NUM_FU = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              insn_valid,
  input logic [NUM_FU-1:0] insn_fu_mask,
  input logic [NUM_FU-1:0] fu_busy,
  input logic              insn_ready,
  input logic [NUM_FU-1:0] fu_issue,
  input logic              illegal
);

  p_onehot_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fu_issue));

  p_issue_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fu_issue != '0) |=> (fu_issue == '0));

  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    insn_ready |-> (fu_issue == '0));

  p_lowest_pick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_ready && insn_fu_mask != '0) |=>
      (fu_issue == ($past(insn_fu_mask) & (~$past(insn_fu_mask) + 1'b1))));

  p_illegal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_ready && insn_fu_mask == '0) |=>
      (illegal && insn_ready && fu_issue == '0));

  p_no_early_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fu_issue != '0) |=> !insn_ready);

  p_ignore_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!insn_ready) |=> !illegal);

endmodule

bind fu_dispatch fu_dispatch_chk #(.NUM_FU(NUM_FU)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid),
  .insn_fu_mask(insn_fu_mask), .fu_busy(fu_busy), .insn_ready(insn_ready),
  .fu_issue(fu_issue), .illegal(illegal)
);

// File: tb/fu_dispatch_tb.sv
module fu_dispatch_tb;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         insn_valid = 1'b0;
  logic [N-1:0] insn_fu_mask = '0;
  logic [N-1:0] fu_busy = '0;
  logic         insn_ready;
  logic [N-1:0] fu_issue;
  logic         illegal;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fu_dispatch #(.NUM_FU(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid),
    .insn_fu_mask(insn_fu_mask), .fu_busy(fu_busy),
    .insn_ready(insn_ready), .fu_issue(fu_issue), .illegal(illegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_one(input logic [N-1:0] m, input int lat);
    logic [N-1:0] exp_sel;
    logic [N-1:0] other;
    exp_sel = m & (~m + 1'b1);
    other   = (exp_sel == 5'b10000) ? 5'b00001 : (exp_sel << 1);
    @(negedge clk);
    chk("R2 ready idle", insn_ready, 1);
    insn_valid = 1'b1; insn_fu_mask = m;
    @(negedge clk);
    insn_valid = 1'b0;
    if (m == '0) begin
      chk("R5 illegal pulse", illegal, 1);
      chk("R5 no enable", fu_issue, 0);
      chk("R5 ready kept", insn_ready, 1);
      @(negedge clk);
      chk("R5 illegal one cycle", illegal, 0);
      return;
    end
    chk("R3 lowest unit", fu_issue, exp_sel);
    chk("R2 ready low", insn_ready, 0);
    @(negedge clk);
    chk("R4 enable one cycle", fu_issue, 0);
    fu_busy = other;
    insn_valid = 1'b1; insn_fu_mask = '0;
    repeat (2) begin
      @(negedge clk);
      chk("R6 wait for own busy", insn_ready, 0);
      chk("R8 valid ignored", illegal, 0);
    end
    insn_valid = 1'b0;
    fu_busy = exp_sel;
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      chk("R7 busy holds", insn_ready, 0);
      chk("R4 no reissue", fu_issue, 0);
    end
    fu_busy = '0;
    @(negedge clk);
    chk("R7 ready after done", insn_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready", insn_ready, 1);
    chk("R1 issue", fu_issue, 0);
    chk("R1 illegal", illegal, 0);
    rst_n = 1'b1;
    for (int m = 0; m < 32; m++) run_one(m[N-1:0], (m % 3) + 1);
    run_one(5'b00000, 1);
    run_one(5'b11111, 2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule